// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block holds outgoing audio samples between a processor and a serial codec link. Software writes 32-bit data words. Each word is turned into a 20-bit entry, with the sample left-justified according to a programmable sample width. In the packed-pair mode, one word carries two 16-bit halves and produces two entries.

The FIFO releases entries as stereo (left, right) pairs through a valid/ready handshake on the codec side. A release burst starts only when the transmitter is enabled, a data slot is selected and the FIFO is at least half full. Four status flags report the fill state: empty, half-empty, full and underrun.

A single control word sets the interface enable, the transmit enable, the sample width, the packed-pair request and the two data-slot selects. While the interface enable is clear, the FIFO is held flushed.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, and in every cycle after a cycle in which the stored interface-enable bit (control bit 0) is clear, the FIFO is empty: empty=1, half-empty=1, full=0, underrun=0 and pairValid=0. A data write made while that bit is clear is dropped.
- R2: The width field (control bits 3:2) selects 16 bits for 0, 18 for 1, 20 for 2 and 12 for 3. In single mode, a write stores one entry equal to the word shifted left by (20 minus width) and kept to its low 20 bits.
- R3: In packed-pair mode (control bit 4, width 12 or 16), a write stores two entries. The first is bits 15:0 and the second is bits 31:16, each shifted left by (20 minus width) and kept to 20 bits.
- R4: A packed-pair request is ignored when the width is 18 or 20. Such a write stores a single entry as in R2.
- R5: A single-mode write is taken only while the level is below DEPTH. A packed-pair write is taken only while level+2 is strictly below DEPTH. Any other write is dropped and changes no state.
- R6: A pair is offered (pairValid=1) only when the interface and transmit enables (bits 0 and 1) are set, slot 3 or slot 4 (bit 5 or 6) is selected and at least two entries are held. A burst may start only when the level is at least DEPTH/2.
- R7: The oldest entry is presented as left and the next one as right. The pair leaves only in a cycle with codecReady=1, and it stays stable while the codec holds off. A burst continues through pairs that are taken back to back while two or more entries remain, even below half depth. It ends at the first cycle the codec refuses a pair.
- R8: A taken write clears empty and underrun. It clears half-empty when the resulting level is at least DEPTH/2, and it sets full when the level reaches DEPTH.
- R9: A released pair clears full. It sets half-empty when the level after release is at most DEPTH/2, and it sets both empty and underrun when the level reaches zero. A write and a release in the same cycle apply the write effects first.
- R10: Writing a control word with the interface-enable bit clear discards all held entries. The next pairValid is 0, and from the cycle after that the flags are back in their reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgData | input | 7 | Control word: bit0 interface enable, bit1 transmit enable, bits3:2 width, bit4 packed-pair, bit5 slot 3, bit6 slot 4 |
| wrEn | input | 1 | Data word write strobe |
| wrData | input | 32 | Data word |
| codecReady | input | 1 | Codec accepts the offered pair |
| pairValid | output | 1 | A left/right pair is offered |
| pairLeft | output | 20 | Left sample of the offered pair |
| pairRight | output | 20 | Right sample of the offered pair |
| stEmpty | output | 1 | Empty flag |
| stHalfEmpty | output | 1 | Half-empty flag |
| stFull | output | 1 | Full flag |
| stUnderrun | output | 1 | Underrun flag |

## Verification
Each of the four widths is written in single mode with words whose upper bits are all ones. A wrong shift or a missing 20-bit mask therefore shows up in the drained samples. Packed-pair writes use different upper and lower halves, which exposes a swapped order or a wrong shift, and the 18-bit and 20-bit packed requests show whether the request is really ignored. Fill runs with the drain blocked exercise both acceptance limits, and runs with enables or slots missing show whether the release gate holds. Long random runs mix writes, a random ready and control changes, which separates burst continuation, same-cycle write and release, and flag ordering.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int SAMPLE_W = 20;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // control word field positions
  localparam int CFG_W = 7;
  localparam int CFG_IFEN = 0;
  localparam int CFG_TXEN = 1;
  localparam int CFG_SIZE = 2;
  localparam int CFG_PACK = 4;
  localparam int CFG_SLOT3 = 5;
  localparam int CFG_SLOT4 = 6;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } sampleSize_e;

  typedef struct packed {
    logic flush;
    logic pushOne;
    logic pushTwo;
    logic popPair;
    sampleSize_e size;
  } fifoCmd_t;

  function automatic int sampleBits(input sampleSize_e s);
    case (s)
      SZ_12: return 12;
      SZ_18: return 18;
      SZ_20: return 20;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoCmd_t            cmd,
  input  logic [WORD_W-1:0]   wrData,
  output logic [LVL_W-1:0]    level,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);
  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, wrPtrInc, rdPtrInc;
  logic [SAMPLE_W-1:0] wideSample, loSample, hiSample;
  logic [WORD_W-1:0] loExt, hiExt;
  logic [LVL_W-1:0] addCnt, subCnt;
  int padShift;

  assign wrPtrInc = wrPtr + AW'(1);
  assign rdPtrInc = rdPtr + AW'(1);
  assign loExt = WORD_W'(wrData[HALF_W-1:0]);
  assign hiExt = WORD_W'(wrData[WORD_W-1:HALF_W]);

  // left-justify into a 20-bit entry
  always_comb begin
    padShift = SAMPLE_W - sampleBits(cmd.size);
    wideSample = SAMPLE_W'(wrData << padShift);
    loSample = SAMPLE_W'(loExt << padShift);
    hiSample = SAMPLE_W'(hiExt << padShift);
  end

  always_ff @(posedge clk) begin
    if (cmd.pushOne) store[wrPtr] <= wideSample;
    if (cmd.pushTwo) begin
      store[wrPtr] <= loSample;
      store[wrPtrInc] <= hiSample;
    end
  end

  assign addCnt = cmd.pushTwo ? LVL_W'(2) : (cmd.pushOne ? LVL_W'(1) : '0);
  assign subCnt = cmd.popPair ? LVL_W'(2) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(addCnt);
      rdPtr <= rdPtr + AW'(subCnt);
      level <= level + addCnt - subCnt;
    end
  end

  assign outLeft = store[rdPtr];
  assign outRight = store[rdPtrInc];
endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             wrEn,
  input  logic             codecReady,
  input  logic [LVL_W-1:0] level,
  output fifoCmd_t         cmd,
  output logic             pairValid,
  output logic             stEmpty,
  output logic             stHalfEmpty,
  output logic             stFull,
  output logic             stUnderrun
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] PACK_LIM = LVL_W'(DEPTH - 2);
  localparam logic [LVL_W-1:0] PAIR_L = LVL_W'(2);

  logic [CFG_W-1:0] cfgQ;
  logic ifEn, txEn, slotOn, packOk, drainGo, burstQ;
  logic [LVL_W-1:0] levelW, levelF;
  logic nEmpty, nHalf, nFull, nUnder;
  sampleSize_e sizeSel;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgData;
  end

  assign ifEn = cfgQ[CFG_IFEN];
  assign txEn = cfgQ[CFG_TXEN];
  assign slotOn = cfgQ[CFG_SLOT3] | cfgQ[CFG_SLOT4];
  assign sizeSel = sampleSize_e'(cfgQ[CFG_SIZE +: 2]);
  assign packOk = cfgQ[CFG_PACK] && (sizeSel == SZ_16 || sizeSel == SZ_12);
  assign drainGo = ifEn && txEn && slotOn;

  assign pairValid = drainGo && (level >= PAIR_L) && ((level >= HALF_L) || burstQ);

  always_comb begin
    cmd.flush = !ifEn;
    cmd.size = sizeSel;
    cmd.pushOne = wrEn && ifEn && !packOk && (level < DEPTH_L);
    cmd.pushTwo = wrEn && ifEn && packOk && (level < PACK_LIM);
    cmd.popPair = pairValid && codecReady;
  end

  assign levelW = level + (cmd.pushTwo ? LVL_W'(2) : (cmd.pushOne ? LVL_W'(1) : '0));
  assign levelF = levelW - (cmd.popPair ? PAIR_L : '0);

  // write effects first, then release effects
  always_comb begin
    nEmpty = stEmpty;
    nHalf = stHalfEmpty;
    nFull = stFull;
    nUnder = stUnderrun;
    if (cmd.pushOne || cmd.pushTwo) begin
      nEmpty = 1'b0;
      nUnder = 1'b0;
      if (levelW >= HALF_L) nHalf = 1'b0;
      if (levelW >= DEPTH_L) nFull = 1'b1;
    end
    if (cmd.popPair) begin
      nFull = 1'b0;
      if (levelF <= HALF_L) nHalf = 1'b1;
      if (levelF == '0) begin
        nEmpty = 1'b1;
        nUnder = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      stEmpty <= 1'b1;
      stHalfEmpty <= 1'b1;
      stFull <= 1'b0;
      stUnderrun <= 1'b0;
      burstQ <= 1'b0;
    end else begin
      stEmpty <= nEmpty;
      stHalfEmpty <= nHalf;
      stFull <= nFull;
      stUnderrun <= nUnder;
      burstQ <= cmd.popPair && (levelF >= PAIR_L);
    end
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic                wrEn,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                codecReady,
  output logic                pairValid,
  output logic [SAMPLE_W-1:0] pairLeft,
  output logic [SAMPLE_W-1:0] pairRight,
  output logic                stEmpty,
  output logic                stHalfEmpty,
  output logic                stFull,
  output logic                stUnderrun
);
  fifoCmd_t fifoCmd;
  logic [LVL_W-1:0] fifoLevel;

  audio_tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .wrEn(wrEn),
    .codecReady(codecReady), .level(fifoLevel), .cmd(fifoCmd), .pairValid(pairValid),
    .stEmpty(stEmpty), .stHalfEmpty(stHalfEmpty), .stFull(stFull), .stUnderrun(stUnderrun)
  );

  audio_tx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .wrData(wrData), .level(fifoLevel),
    .outLeft(pairLeft), .outRight(pairRight)
  );
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWe,
  input logic [CFG_W-1:0]    cfgData,
  input logic                codecReady,
  input logic                pairValid,
  input logic [SAMPLE_W-1:0] pairLeft,
  input logic [SAMPLE_W-1:0] pairRight,
  input logic                stEmpty,
  input logic                stHalfEmpty,
  input logic                stFull,
  input logic                stUnderrun,
  input logic [LVL_W-1:0]    fifoLevel
);
  // R1
  empty_tracks_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    stEmpty == (fifoLevel == '0));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  // R6
  offer_needs_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (fifoLevel >= LVL_W'(2)) && !stEmpty);

  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && !codecReady && !cfgWe |=> $stable(pairLeft) && $stable(pairRight));

  // R8
  full_clears_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    stFull |-> !stHalfEmpty && !stEmpty);

  // R9
  underrun_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stUnderrun) |-> stEmpty);

  // R10
  disable_stops_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && !cfgData[CFG_IFEN] |=> !pairValid);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .codecReady(codecReady),
  .pairValid(pairValid), .pairLeft(pairLeft), .pairRight(pairRight), .stEmpty(stEmpty),
  .stHalfEmpty(stHalfEmpty), .stFull(stFull), .stUnderrun(stUnderrun), .fifoLevel(fifoLevel)
);

// File: tb/audio_tx_fifo_bench.sv
module audio_tx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [6:0] cfgData = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic codecReady = 1'b0;
  logic pairValid, stEmpty, stHalfEmpty, stFull, stUnderrun;
  logic [19:0] pairLeft, pairRight;

  audio_tx_fifo #(.DEPTH(DEPTH)) u_audio_tx_fifo (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .wrEn(wrEn), .wrData(wrData),
    .codecReady(codecReady), .pairValid(pairValid), .pairLeft(pairLeft), .pairRight(pairRight),
    .stEmpty(stEmpty), .stHalfEmpty(stHalfEmpty), .stFull(stFull), .stUnderrun(stUnderrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit armed = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  logic [19:0] mq[$];
  logic [6:0] mCfg = '0;
  bit mBurst = 0;
  bit mE = 1, mH = 1, mF = 0, mU = 0;

  function automatic int widthOf(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 12;
    endcase
  endfunction

  function automatic logic [6:0] mk(input bit ifE, input bit txE, input logic [1:0] sz,
                                    input bit pk, input bit s3, input bit s4);
    return {s4, s3, pk, sz, txE, ifE};
  endfunction

  function automatic bit mValid();
    return mCfg[0] && mCfg[1] && (mCfg[5] || mCfg[6]) && mq.size() >= 2 &&
           (mq.size() >= HALF || mBurst);
  endfunction

  task automatic check(input string name, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit pop;
    bit pack;
    int w;
    int sh;
    logic [31:0] v;
    cycles++;
    if (!rstN) begin
      mq.delete();
      mCfg = '0;
      mBurst = 0;
      {mE, mH, mF, mU} = 4'b1100;
    end else begin
      if (!mCfg[0]) begin
        mq.delete();
        mBurst = 0;
        {mE, mH, mF, mU} = 4'b1100;
      end else begin
        pop = mValid() && codecReady;
        w = widthOf(mCfg[3:2]);
        sh = 20 - w;
        pack = mCfg[4] && (w == 16 || w == 12);
        v = wrData;
        if (wrEn && ((!pack && mq.size() < DEPTH) || (pack && mq.size() + 2 < DEPTH))) begin
          if (pack) begin
            mq.push_back(20'((v & 32'hFFFF) << sh));
            mq.push_back(20'((v >> 16) << sh));
          end else begin
            mq.push_back(20'(v << sh));
          end
          mE = 0;
          mU = 0;
          if (mq.size() >= HALF) mH = 0;
          if (mq.size() >= DEPTH) mF = 1;
        end
        if (pop) begin
          void'(mq.pop_front());
          void'(mq.pop_front());
          mF = 0;
          if (mq.size() <= HALF) mH = 1;
          if (mq.size() == 0) begin
            mE = 1;
            mU = 1;
          end
        end
        mBurst = pop && mq.size() >= 2;
      end
      if (cfgWe) mCfg = cfgData;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      check("pairValid", 32'(pairValid), 32'(mValid()));
      check("flags{E,H,F,U}", 32'({stEmpty, stHalfEmpty, stFull, stUnderrun}),
            32'({mE, mH, mF, mU}));
      if (mValid()) begin
        check("pairLeft", 32'(pairLeft), 32'(mq[0]));
        check("pairRight", 32'(pairRight), 32'(mq[1]));
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic setCfg(input logic [6:0] c);
    cfgWe = 1;
    cfgData = c;
    cyc();
    cfgWe = 0;
  endtask

  task automatic pushWord(input logic [31:0] d);
    wrEn = 1;
    wrData = d;
    cyc();
    wrEn = 0;
  endtask

  initial begin
    idle(3);
    rstN = 1;
    armed = 1;

    // R1: reset state, write while interface disabled is dropped
    tag = "R1";
    idle(2);
    pushWord(32'h000ABCDE);
    idle(2);

    // R2: every width in single mode, upper bits set to expose masking
    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      setCfg(mk(1, 0, 2'(s), 0, 0, 0));
      for (int k = 0; k < 4; k++) pushWord(32'hFFF0_0000 | 32'(k * 32'h1357 + 32'h9A5));
      codecReady = 1;
      setCfg(mk(1, 1, 2'(s), 0, 1, 0));
      idle(4);
      codecReady = 0;
      setCfg(7'd0);
      idle(1);
    end

    // R3: packed-pair split order and shift for 16 and 12 bits
    tag = "R3";
    for (int s = 0; s < 4; s += 3) begin
      setCfg(mk(1, 0, 2'(s), 1, 0, 0));
      pushWord(32'hA1B2_C3D4);
      pushWord(32'h5E6F_7081);
      codecReady = 1;
      setCfg(mk(1, 1, 2'(s), 1, 0, 1));
      idle(4);
      codecReady = 0;
      setCfg(7'd0);
      idle(1);
    end

    // R4: packed-pair request ignored at 18 and 20 bits
    tag = "R4";
    for (int s = 1; s < 3; s++) begin
      setCfg(mk(1, 0, 2'(s), 1, 0, 0));
      for (int k = 0; k < 4; k++) pushWord(32'hC0DE_0000 + 32'(k * 32'h2468));
      codecReady = 1;
      setCfg(mk(1, 1, 2'(s), 1, 1, 1));
      idle(4);
      codecReady = 0;
      setCfg(7'd0);
      idle(1);
    end

    // R5: acceptance limits in both modes
    tag = "R5";
    setCfg(mk(1, 0, 2'd2, 0, 0, 0));
    for (int k = 0; k < 10; k++) pushWord(32'(k + 1));
    idle(2);
    setCfg(7'd0);
    setCfg(mk(1, 0, 2'd0, 1, 0, 0));
    for (int k = 0; k < 5; k++) pushWord(32'(32'h0001_0002 * (k + 1)));
    codecReady = 1;
    setCfg(mk(1, 1, 2'd0, 1, 1, 0));
    idle(6);
    codecReady = 0;
    setCfg(7'd0);

    // R6: no release without a slot, then slot 4 alone releases
    tag = "R6";
    codecReady = 1;
    setCfg(mk(1, 1, 2'd2, 0, 0, 0));
    for (int k = 0; k < 6; k++) pushWord(32'(k * 32'h111));
    idle(3);
    setCfg(mk(1, 1, 2'd2, 0, 0, 1));
    idle(5);
    codecReady = 0;
    setCfg(7'd0);

    // R7: codec holds off, then random acceptance
    tag = "R7";
    setCfg(mk(1, 1, 2'd2, 0, 1, 0));
    for (int k = 0; k < 6; k++) pushWord(32'(32'h5000 + k));
    idle(3);
    for (int k = 0; k < 30; k++) begin
      codecReady = 1'($urandom_range(0, 1));
      if (k % 7 == 0) begin
        wrEn = 1;
        wrData = $urandom();
      end
      cyc();
      wrEn = 0;
    end
    codecReady = 0;
    setCfg(7'd0);

    // R8 R9: mixed random writes, releases and control changes
    tag = "R8 R9";
    setCfg(mk(1, 1, 2'd0, 0, 1, 1));
    for (int k = 0; k < 1500; k++) begin
      wrEn = 1'($urandom_range(0, 2) != 0);
      wrData = $urandom();
      codecReady = 1'($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 39) == 0) begin
        cfgWe = 1;
        cfgData = {6'($urandom()), 1'($urandom_range(0, 7) != 0)};
      end
      cyc();
      cfgWe = 0;
    end
    wrEn = 0;
    codecReady = 0;

    // R10: disabling discards held entries and blocks writes
    tag = "R10";
    setCfg(mk(1, 0, 2'd2, 0, 0, 0));
    for (int k = 0; k < 7; k++) pushWord(32'(k + 32'h77));
    setCfg(mk(0, 1, 2'd2, 0, 1, 0));
    idle(2);
    pushWord(32'h12345);
    idle(2);
    codecReady = 1;
    setCfg(mk(1, 1, 2'd2, 0, 1, 0));
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule